// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block is the part of an I2C master that opens and closes a bus transaction. It drives two open-drain enables, one for SDA and one for SCL. A high enable pulls the line low and a low enable releases it. A single command write asks for either a START or a STOP. Every setup and hold interval is a count of system-clock cycles. The count is taken from a four-way timing choice, set by the clock-mode input (standard or high-speed) and a long/short select input. STOP intervals are two cycles longer than the matching START intervals.

When a START completes, the block keeps SDA and SCL driven low and hands the bus to the byte-clocking logic. It does this by pulsing `startDone` and clearing the 3-bit bit counter. The byte-clocking logic advances that counter with `bitTick`. A STOP can be requested only while the bus is held after a START. It ends with both lines released, `busy` low and a `stopDone` pulse. A START requested while the block is busy does nothing except raise a one-cycle error pulse.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, `sdaOe` and `sclOe` are 0, `busy` is 0, `startDone`, `stopDone` and `requestError` are 0, and `bitCount` is 0.
- R2: A START is accepted only on a `cmdWr` cycle with `cmdMaster`=1, `cmdTransmit`=1 and `cmdBusy`=1 while `busy` is 0. `busy` is 1 in the cycle after the write. Any other write while idle leaves `busy` at 0 and both enables at 0.
- R3: START shape: both lines are released for Tsu cycles, then `sdaOe`=1 with `sclOe`=0 for Th cycles, then both are 1.
- R4: START Tsu = Th = 20 (`fastMode`=0, `longSel`=0), 52 (0,1), 10 (1,0), 26 (1,1).
- R5: STOP Tsu = Th = 22 (`fastMode`=0, `longSel`=0), 54 (0,1), 12 (1,0), 28 (1,1).
- R6: `startDone` is a one-cycle pulse in the first cycle in which both lines are driven after a START, and `bitCount` reads 0 in that cycle.
- R7: A STOP is accepted only on a `cmdWr` cycle with `cmdMaster`=1, `cmdTransmit`=1, `cmdBusy`=0 and `ifEnable`=1 while the bus is held after a START. Otherwise the bus stays held, with `busy`=1, `sclOe`=1 and no `stopDone`.
- R8: STOP shape: one cycle with both lines driven, then `sdaOe`=1 and `sclOe`=0 for Tsu cycles, then both released with `busy`=1 for Th cycles. Then `busy` is 0 and `stopDone` pulses for one cycle.
- R9: A START request while `busy` is 1 is ignored and gives a one-cycle `requestError` pulse in the cycle after the write.
- R10: The timing choice is taken when the request is accepted. Changing `fastMode` or `longSel` during a sequence does not alter its intervals.
- R11: Each cycle with `bitTick`=1 advances `bitCount` by one, modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | Command write strobe |
| cmdMaster | input | 1 | Master-select value of the command |
| cmdTransmit | input | 1 | Transmit-direction value of the command |
| cmdBusy | input | 1 | Bus-busy value of the command (1 asks for START, 0 for STOP) |
| ifEnable | input | 1 | Interface enable, needed for STOP |
| fastMode | input | 1 | 1 selects high-speed clock mode |
| longSel | input | 1 | 1 selects the long interval set |
| bitTick | input | 1 | Advance the bit counter |
| sdaOe | output | 1 | Pull SDA low |
| sclOe | output | 1 | Pull SCL low |
| busy | output | 1 | Bus owned or sequence running |
| startDone | output | 1 | One-cycle pulse at START completion |
| stopDone | output | 1 | One-cycle pulse at STOP completion |
| requestError | output | 1 | One-cycle pulse on a START refused as busy |
| bitCount | output | 3 | Bit counter value |

## Verification
The bench runs a START and a STOP at each of the four mode/select combinations. It measures each line phase in cycles, which shows a wrong table entry, a START/STOP mix-up or an off-by-one counter load apart from a wrong phase order. In a held bus it sends a second START, a STOP with the enable low, and a STOP with the direction bit clear, to tell a refused request from one that was wrongly accepted. It also sends stray writes to an idle bus. It flips the mode inputs right after a request to show the interval is latched. It counts bit ticks past the wrap and checks the counter clear at START completion.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_ST_SETUP,
    CS_ST_HOLD,
    CS_OWNED,
    CS_SP_PREP,
    CS_SP_SETUP,
    CS_SP_HOLD
  } condState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCfg;  // capture fastMode/longSel
    logic loadCnt;   // load interval counter
    logic useLive;   // take interval from live inputs, not latched copy
    logic isStop;    // STOP interval set
    logic decCnt;    // count down
    logic clrBits;   // clear bit counter
  } dpStrobe_t;

endpackage

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
#(
  parameter int unsigned ST_STD_SHORT = 20,
  parameter int unsigned ST_STD_LONG  = 52,
  parameter int unsigned ST_HS_SHORT  = 10,
  parameter int unsigned ST_HS_LONG   = 26,
  parameter int unsigned SP_STD_SHORT = 22,
  parameter int unsigned SP_STD_LONG  = 54,
  parameter int unsigned SP_HS_SHORT  = 12,
  parameter int unsigned SP_HS_LONG   = 28,
  parameter int unsigned BITS_PER_BYTE = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpStrobe_t                        st,
  input  logic                             fastMode,
  input  logic                             longSel,
  input  logic                             bitTick,
  output logic                             cntZero,
  output logic [$clog2(BITS_PER_BYTE)-1:0] bitCount
);

  localparam int unsigned MAX_A = (ST_STD_LONG > SP_STD_LONG) ? ST_STD_LONG : SP_STD_LONG;
  localparam int unsigned MAX_B = (ST_STD_SHORT > SP_STD_SHORT) ? ST_STD_SHORT : SP_STD_SHORT;
  localparam int unsigned MAX_C = (ST_HS_LONG > SP_HS_LONG) ? ST_HS_LONG : SP_HS_LONG;
  localparam int unsigned MAX_D = (ST_HS_SHORT > SP_HS_SHORT) ? ST_HS_SHORT : SP_HS_SHORT;
  localparam int unsigned MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CD = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int unsigned MAX_DUR = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W = $clog2(MAX_DUR + 1);
  localparam int unsigned BIT_W = $clog2(BITS_PER_BYTE);

  function automatic logic [CNT_W-1:0] pickDur(input logic fast, input logic lng,
                                               input logic stp);
    int unsigned v;
    case ({stp, fast, lng})
      3'b000:  v = ST_STD_SHORT;
      3'b001:  v = ST_STD_LONG;
      3'b010:  v = ST_HS_SHORT;
      3'b011:  v = ST_HS_LONG;
      3'b100:  v = SP_STD_SHORT;
      3'b101:  v = SP_STD_LONG;
      3'b110:  v = SP_HS_SHORT;
      default: v = SP_HS_LONG;
    endcase
    return CNT_W'(v);
  endfunction

  logic             cfgFast, cfgLong;
  logic             selFast, selLong;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] durNext;

  assign selFast = st.useLive ? fastMode : cfgFast;
  assign selLong = st.useLive ? longSel  : cfgLong;
  assign durNext = pickDur(selFast, selLong, st.isStop);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFast <= 1'b0;
      cfgLong <= 1'b0;
    end else if (st.latchCfg) begin
      cfgFast <= fastMode;
      cfgLong <= longSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (st.loadCnt) begin
      cnt <= durNext - CNT_W'(1);
    end else if (st.decCnt && !cntZero) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (st.clrBits) begin
      bitCount <= '0;
    end else if (bitTick) begin
      bitCount <= bitCount + BIT_W'(1);
    end
  end

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWr,
  input  logic      cmdMaster,
  input  logic      cmdTransmit,
  input  logic      cmdBusy,
  input  logic      ifEnable,
  input  logic      cntZero,
  output dpStrobe_t st,
  output logic      sdaOe,
  output logic      sclOe,
  output logic      busy,
  output logic      startDone,
  output logic      stopDone,
  output logic      requestError
);

  condState_t state, stateNext;
  logic       startReq, stopReq;

  assign startReq = cmdWr & cmdMaster & cmdTransmit & cmdBusy;
  assign stopReq  = cmdWr & cmdMaster & cmdTransmit & ~cmdBusy & ifEnable;

  always_comb begin
    stateNext = state;
    st        = '0;
    case (state)
      CS_IDLE: begin
        if (startReq) begin
          stateNext   = CS_ST_SETUP;
          st.latchCfg = 1'b1;
          st.loadCnt  = 1'b1;
          st.useLive  = 1'b1;
        end
      end
      CS_ST_SETUP: begin
        if (cntZero) begin
          stateNext  = CS_ST_HOLD;
          st.loadCnt = 1'b1;
        end else begin
          st.decCnt = 1'b1;
        end
      end
      CS_ST_HOLD: begin
        if (cntZero) begin
          stateNext  = CS_OWNED;
          st.clrBits = 1'b1;
        end else begin
          st.decCnt = 1'b1;
        end
      end
      CS_OWNED: begin
        if (stopReq) begin
          stateNext   = CS_SP_PREP;
          st.latchCfg = 1'b1;
        end
      end
      CS_SP_PREP: begin
        stateNext  = CS_SP_SETUP;
        st.loadCnt = 1'b1;
        st.isStop  = 1'b1;
      end
      CS_SP_SETUP: begin
        st.isStop = 1'b1;
        if (cntZero) begin
          stateNext  = CS_SP_HOLD;
          st.loadCnt = 1'b1;
        end else begin
          st.decCnt = 1'b1;
        end
      end
      CS_SP_HOLD: begin
        st.isStop = 1'b1;
        if (cntZero) begin
          stateNext = CS_IDLE;
        end else begin
          st.decCnt = 1'b1;
        end
      end
      default: stateNext = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= CS_IDLE;
      startDone    <= 1'b0;
      stopDone     <= 1'b0;
      requestError <= 1'b0;
    end else begin
      state        <= stateNext;
      startDone    <= (state == CS_ST_HOLD) && cntZero;
      stopDone     <= (state == CS_SP_HOLD) && cntZero;
      requestError <= startReq && (state != CS_IDLE);
    end
  end

  assign busy  = (state != CS_IDLE);
  assign sdaOe = (state == CS_ST_HOLD) || (state == CS_OWNED) ||
                 (state == CS_SP_PREP) || (state == CS_SP_SETUP);
  assign sclOe = (state == CS_OWNED) || (state == CS_SP_PREP);

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int unsigned ST_STD_SHORT = 20,
  parameter int unsigned ST_STD_LONG  = 52,
  parameter int unsigned ST_HS_SHORT  = 10,
  parameter int unsigned ST_HS_LONG   = 26,
  parameter int unsigned SP_STD_SHORT = 22,
  parameter int unsigned SP_STD_LONG  = 54,
  parameter int unsigned SP_HS_SHORT  = 12,
  parameter int unsigned SP_HS_LONG   = 28,
  parameter int unsigned BITS_PER_BYTE = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cmdWr,
  input  logic                             cmdMaster,
  input  logic                             cmdTransmit,
  input  logic                             cmdBusy,
  input  logic                             ifEnable,
  input  logic                             fastMode,
  input  logic                             longSel,
  input  logic                             bitTick,
  output logic                             sdaOe,
  output logic                             sclOe,
  output logic                             busy,
  output logic                             startDone,
  output logic                             stopDone,
  output logic                             requestError,
  output logic [$clog2(BITS_PER_BYTE)-1:0] bitCount
);

  dpStrobe_t st;
  logic      cntZero;

  i2c_cond_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWr        (cmdWr),
    .cmdMaster    (cmdMaster),
    .cmdTransmit  (cmdTransmit),
    .cmdBusy      (cmdBusy),
    .ifEnable     (ifEnable),
    .cntZero      (cntZero),
    .st           (st),
    .sdaOe        (sdaOe),
    .sclOe        (sclOe),
    .busy         (busy),
    .startDone    (startDone),
    .stopDone     (stopDone),
    .requestError (requestError)
  );

  i2c_cond_dp #(
    .ST_STD_SHORT (ST_STD_SHORT),
    .ST_STD_LONG  (ST_STD_LONG),
    .ST_HS_SHORT  (ST_HS_SHORT),
    .ST_HS_LONG   (ST_HS_LONG),
    .SP_STD_SHORT (SP_STD_SHORT),
    .SP_STD_LONG  (SP_STD_LONG),
    .SP_HS_SHORT  (SP_HS_SHORT),
    .SP_HS_LONG   (SP_HS_LONG),
    .BITS_PER_BYTE(BITS_PER_BYTE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .fastMode (fastMode),
    .longSel  (longSel),
    .bitTick  (bitTick),
    .cntZero  (cntZero),
    .bitCount (bitCount)
  );

endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk #(
  parameter int unsigned BIT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             sdaOe,
  input logic             sclOe,
  input logic             startDone,
  input logic             stopDone,
  input logic             requestError,
  input logic [BIT_W-1:0] bitCount
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sdaOe && !sclOe)); // R1

  AST_START_OPENS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!sdaOe && !sclOe)); // R3

  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> sdaOe); // R3

  AST_STARTDONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone); // R6

  AST_STARTDONE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> (bitCount == '0 && sclOe && sdaOe)); // R6

  AST_STOPDONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopDone |-> (!busy && $past(busy))); // R8

  AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    requestError |-> ($past(busy) && busy)); // R9

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    requestError |=> !requestError); // R9

endmodule

bind i2c_cond_gen i2c_cond_chk #(.BIT_W($clog2(BITS_PER_BYTE))) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busy         (busy),
  .sdaOe        (sdaOe),
  .sclOe        (sclOe),
  .startDone    (startDone),
  .stopDone     (stopDone),
  .requestError (requestError),
  .bitCount     (bitCount)
);

// File: tb/i2c_cond_gen_bench.sv
module i2c_cond_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWr = 1'b0, cmdMaster = 1'b0, cmdTransmit = 1'b0, cmdBusy = 1'b0;
  logic       ifEnable = 1'b1, fastMode = 1'b0, longSel = 1'b0, bitTick = 1'b0;
  logic       sdaOe, sclOe, busy, startDone, stopDone, requestError;
  logic [2:0] bitCount;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_cond_gen u_i2c_cond_gen (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdMaster(cmdMaster),
    .cmdTransmit(cmdTransmit), .cmdBusy(cmdBusy), .ifEnable(ifEnable),
    .fastMode(fastMode), .longSel(longSel), .bitTick(bitTick),
    .sdaOe(sdaOe), .sclOe(sclOe), .busy(busy), .startDone(startDone),
    .stopDone(stopDone), .requestError(requestError), .bitCount(bitCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      summary();
    end
  end

  function automatic int startDur(input bit f, input bit l);
    return f ? (l ? 26 : 10) : (l ? 52 : 20);
  endfunction

  function automatic int stopDur(input bit f, input bit l);
    return startDur(f, l) + 2;
  endfunction

  // Drive a write at a negedge; returns at the negedge after the write edge
  task automatic writeCmd(input bit m, input bit t, input bit b);
    @(negedge clk);
    cmdWr = 1; cmdMaster = m; cmdTransmit = t; cmdBusy = b;
    @(negedge clk);
    cmdWr = 0; cmdMaster = 0; cmdTransmit = 0; cmdBusy = 0;
  endtask

  task automatic runStart(input bit f, input bit l, input bit flip, input string tag);
    int n;
    fastMode = f; longSel = l;
    writeCmd(1, 1, 1);
    if (flip) begin fastMode = ~f; longSel = ~l; end
    chk(busy == 1'b1, "R2 busy after START write", busy, 1);
    n = 0;
    while (busy && !sdaOe && !sclOe && n < 200) begin n++; @(negedge clk); end
    chk(n == startDur(f, l), {tag, " START setup"}, n, startDur(f, l));
    n = 0;
    while (sdaOe && !sclOe && n < 200) begin n++; @(negedge clk); end
    chk(n == startDur(f, l), {tag, " START hold"}, n, startDur(f, l));
    chk(sdaOe && sclOe, "R3 both driven after START", {sdaOe, sclOe}, 3);
    chk(startDone == 1'b1 && bitCount == 3'd0, "R6 startDone and bitCount clear",
        {startDone, bitCount}, 8);
    @(negedge clk);
    chk(startDone == 1'b0, "R6 startDone one cycle", startDone, 0);
  endtask

  task automatic runStop(input bit f, input bit l, input bit flip, input string tag);
    int n;
    fastMode = f; longSel = l;
    writeCmd(1, 1, 0);
    if (flip) begin fastMode = ~f; longSel = ~l; end
    chk(sdaOe && sclOe && busy, "R8 STOP prep both driven", {sdaOe, sclOe, busy}, 7);
    @(negedge clk);
    n = 0;
    while (sdaOe && !sclOe && n < 200) begin n++; @(negedge clk); end
    chk(n == stopDur(f, l), {tag, " STOP setup"}, n, stopDur(f, l));
    n = 0;
    while (busy && !sdaOe && !sclOe && n < 200) begin n++; @(negedge clk); end
    chk(n == stopDur(f, l), {tag, " STOP hold"}, n, stopDur(f, l));
    chk(!busy && stopDone, "R8 idle with stopDone", {busy, stopDone}, 1);
    @(negedge clk);
    chk(!stopDone && !sdaOe && !sclOe, "R8 stopDone one cycle", {stopDone, sdaOe, sclOe}, 0);
  endtask

  task automatic heldCheck(input string tag);
    chk(busy && sclOe && sdaOe && !stopDone, tag, {busy, sclOe, sdaOe, stopDone}, 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sdaOe && !sclOe && !busy && !startDone && !stopDone && !requestError && bitCount == 0,
        "R1 reset state", {sdaOe, sclOe, busy, startDone, stopDone, requestError}, 0);
    rstN = 1;
    @(negedge clk);

    // R11 bit counter wraps modulo 8
    for (int i = 1; i <= 10; i++) begin
      bitTick = 1; @(negedge clk); bitTick = 0;
      chk(bitCount == 3'(i % 8), "R11 bitCount step", bitCount, i % 8);
    end

    // R2 stray writes while idle are ignored
    writeCmd(1, 0, 1);
    chk(!busy && !sdaOe && !sclOe, "R2 TRX=0 ignored", busy, 0);
    writeCmd(0, 1, 1);
    chk(!busy && !sdaOe && !sclOe, "R2 MST=0 ignored", busy, 0);
    writeCmd(1, 1, 0);
    chk(!busy && !sdaOe && !sclOe, "R7 STOP while idle ignored", busy, 0);
    chk(bitCount == 3'd2, "R11 bitCount held", bitCount, 2);

    // R4 R5 sweep over all mode/select combinations
    for (int c = 0; c < 4; c++) begin
      runStart(c[1], c[0], 0, "R4");
      if (c == 0) begin
        // R9 START while held
        writeCmd(1, 1, 1);
        chk(requestError == 1'b1, "R9 requestError pulse", requestError, 1);
        heldCheck("R9 bus kept after refused START");
        @(negedge clk);
        chk(requestError == 1'b0, "R9 requestError one cycle", requestError, 0);
        // R7 STOP with enable low
        ifEnable = 0;
        writeCmd(1, 1, 0);
        repeat (3) @(negedge clk);
        heldCheck("R7 STOP with ifEnable=0 ignored");
        ifEnable = 1;
        writeCmd(1, 0, 0);
        repeat (3) @(negedge clk);
        heldCheck("R7 STOP with TRX=0 ignored");
        chk(requestError == 1'b0, "R9 no error on STOP write", requestError, 0);
        // R11 ticks while held
        bitTick = 1; @(negedge clk); bitTick = 0;
        chk(bitCount == 3'd1, "R11 tick while held", bitCount, 1);
      end
      runStop(c[1], c[0], 0, "R5");
      repeat (2) @(negedge clk);
    end

    // R10 mode inputs flipped right after acceptance
    runStart(1'b0, 1'b1, 1, "R10");
    runStop(1'b1, 1'b0, 1, "R10");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule